// File: doc/BRIEF.md
# Credit-Based Egress Shaper

This block paces several stream classes that share one Ethernet egress port. Each class owns a signed credit register. While a class has frames queued and is not on the wire, its credit climbs by a programmable idle increment every clock. While it is transmitting, the credit falls by a programmable send increment every clock. The send increment is normally the idle increment minus the port rate. A class may begin a new frame only when its credit is zero or above. The effect is that bursts are spread out in time. The price is extra worst-case delay, which may be too much for control traffic.

Frame storage, the MAC and time synchronization live outside the block. The queue logic reports a non-empty flag per class. The MAC reports whether a frame is in flight and which class it belongs to. The shaper returns a per-class eligibility vector, all credit values, and a strict-priority pick among the eligible classes in which the highest class index wins. A frame already in flight always runs to its end, even when its credit goes negative. No new pick is offered while that frame is in flight.

Top module: `cbs_shaper`

## Requirements
- R1: After reset every credit is zero, so with all queues empty no class is eligible and `pick_valid` is 0.
- R2: A class that has a frame waiting and is not the class in flight adds its idle increment to its credit at the next clock edge.
- R3: The class in flight (`tx_busy`=1 and `tx_cls` equal to its index) adds its send increment to its credit at every clock edge. This continues below zero for the whole frame.
- R4: A class with an empty queue that is not in flight and whose credit is zero or positive has its credit set to zero at the next edge.
- R5: A class with an empty queue that is not in flight and whose credit is negative recovers by its idle increment each edge. Recovery stops at zero and never overshoots it.
- R6: Every new credit value is limited to the range [`cred_min`, `cred_max`]. A result beyond either limit is replaced by that limit.
- R7: Bit i of `eligible` is 1 exactly when class i's queue is non-empty and its current credit is zero or positive. The bit follows the queue flag in the same cycle.
- R8: When no frame is in flight, `pick_valid` is 1 if any class is eligible, and `pick_cls` is the highest-indexed eligible class.
- R9: While `tx_busy` is 1, `pick_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | N | Per-class queue holds at least one frame |
| tx_busy | input | 1 | A frame is in flight on the port |
| tx_cls | input | CW | Class of the frame in flight |
| idle_inc | input | N*W | Per-class signed idle increment, class i in bits [i*W +: W] |
| send_inc | input | N*W | Per-class signed send increment, same packing |
| cred_max | input | W | Signed upper credit limit |
| cred_min | input | W | Signed lower credit limit |
| eligible | output | N | Per-class permission to start a frame |
| pick_valid | output | 1 | A class is offered for the next frame |
| pick_cls | output | CW | Highest-indexed eligible class |
| credit | output | N*W | Per-class signed credit, class i in bits [i*W +: W] |

## Verification
A corrupted credit register shows on `credit` at the next edge, since every class's credit is driven straight to the ports. It also changes `eligible` and the pick as soon as its sign is wrong, so a reference model compared on every clock catches it within one cycle. A wrong update choice (accrue versus drain versus clear) appears as a wrong increment in that same cycle. A drift in recovery or saturation appears only when the credit crosses zero or a limit, so the stimulus drives each class through both limits and through zero from both sides.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    typedef enum logic [1:0] {
        UPD_CLEAR   = 2'd0,
        UPD_ACCRUE  = 2'd1,
        UPD_SEND    = 2'd2,
        UPD_RECOVER = 2'd3
    } upd_e;

    // Chooses how a class credit moves this cycle.
    function automatic upd_e pick_mode(input logic waiting, input logic sending,
                                       input logic negative);
        upd_e m;
        if (sending)       m = UPD_SEND;
        else if (waiting)  m = UPD_ACCRUE;
        else if (negative) m = UPD_RECOVER;
        else               m = UPD_CLEAR;
        return m;
    endfunction

endpackage

// File: rtl/cbs_credit_unit.sv
module cbs_credit_unit
    import cbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                waiting,
    input  logic                sending,
    input  logic signed [W-1:0] idle_step,
    input  logic signed [W-1:0] send_step,
    input  logic signed [W-1:0] lim_hi,
    input  logic signed [W-1:0] lim_lo,
    output logic signed [W-1:0] credit
);

    typedef struct packed {
        logic signed [W-1:0] cr;
    } state_t;

    state_t st_d, st_q;
    upd_e   mode;
    logic signed [W:0] sum, wide_hi, wide_lo;

    always_comb begin
        st_d    = st_q;
        wide_hi = {lim_hi[W-1], lim_hi};
        wide_lo = {lim_lo[W-1], lim_lo};
        mode    = pick_mode(waiting, sending, st_q.cr[W-1]);
        unique case (mode)
            UPD_SEND:    sum = {st_q.cr[W-1], st_q.cr} + {send_step[W-1], send_step};
            UPD_ACCRUE:  sum = {st_q.cr[W-1], st_q.cr} + {idle_step[W-1], idle_step};
            UPD_RECOVER: begin
                sum = {st_q.cr[W-1], st_q.cr} + {idle_step[W-1], idle_step};
                if (sum > 0) sum = '0;
            end
            default:     sum = '0;
        endcase
        if (sum > wide_hi)      st_d.cr = lim_hi;
        else if (sum < wide_lo) st_d.cr = lim_lo;
        else                    st_d.cr = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign credit = st_q.cr;

endmodule

// File: rtl/cbs_pick.sv
module cbs_pick #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  elig,
    input  logic          busy,
    output logic          valid,
    output logic [CW-1:0] cls
);

    typedef struct packed {
        logic          any;
        logic [CW-1:0] idx;
    } pick_t;

    pick_t pk_d;

    // Later (higher) indices overwrite earlier ones: highest index wins.
    always_comb begin
        pk_d = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                pk_d.any = 1'b1;
                pk_d.idx = CW'(i);
            end
        end
    end

    assign valid = pk_d.any && !busy;
    assign cls   = pk_d.idx;

endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper #(
    parameter  int N  = 4,
    parameter  int W  = 16,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    q_nonempty,
    input  logic            tx_busy,
    input  logic [CW-1:0]   tx_cls,
    input  logic [N*W-1:0]  idle_inc,
    input  logic [N*W-1:0]  send_inc,
    input  logic [W-1:0]    cred_max,
    input  logic [W-1:0]    cred_min,
    output logic [N-1:0]    eligible,
    output logic            pick_valid,
    output logic [CW-1:0]   pick_cls,
    output logic [N*W-1:0]  credit
);

    for (genvar g = 0; g < N; g++) begin : g_cls
        logic signed [W-1:0] cr_q;
        logic                on_wire;

        assign on_wire = tx_busy && (tx_cls == CW'(g));

        cbs_credit_unit #(.W(W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .waiting   (q_nonempty[g]),
            .sending   (on_wire),
            .idle_step ($signed(idle_inc[g*W +: W])),
            .send_step ($signed(send_inc[g*W +: W])),
            .lim_hi    ($signed(cred_max)),
            .lim_lo    ($signed(cred_min)),
            .credit    (cr_q)
        );

        assign credit[g*W +: W] = cr_q;
        assign eligible[g]      = q_nonempty[g] && !cr_q[W-1];
    end

    cbs_pick #(.N(N), .CW(CW)) u_pick (
        .elig  (eligible),
        .busy  (tx_busy),
        .valid (pick_valid),
        .cls   (pick_cls)
    );

endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk #(
    parameter  int N  = 4,
    parameter  int W  = 16,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    q_nonempty,
    input logic            tx_busy,
    input logic [CW-1:0]   tx_cls,
    input logic [N*W-1:0]  idle_inc,
    input logic [N*W-1:0]  send_inc,
    input logic [W-1:0]    cred_max,
    input logic [W-1:0]    cred_min,
    input logic [N-1:0]    eligible,
    input logic            pick_valid,
    input logic [CW-1:0]   pick_cls,
    input logic [N*W-1:0]  credit
);

    logic signed [W-1:0] cr [N];
    logic [N-1:0]        neg;
    logic signed [W-1:0] hi_s, lo_s;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cr[i]  = $signed(credit[i*W +: W]);
            neg[i] = credit[i*W + W - 1];
        end
    end
    assign hi_s = $signed(cred_max);
    assign lo_s = $signed(cred_min);

    // R9
    pick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !pick_valid);

    // R8
    pick_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((eligible >> pick_cls) == N'(1)));

    // R7
    elig_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eligible & neg) == '0) && ((eligible & ~q_nonempty) == '0));

    for (genvar g = 0; g < N; g++) begin : g_prop
        // R4
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_nonempty[g] && !(tx_busy && tx_cls == CW'(g)) && !neg[g]
             && lo_s <= 0 && hi_s >= 0) |=> (cr[g] == 0));

        // R6
        bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_s <= hi_s) |=> (cr[g] <= $past(hi_s) && cr[g] >= $past(lo_s)));

        // R3
        send_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_busy && tx_cls == CW'(g) && $signed(send_inc[g*W +: W]) <= 0
             && cr[g] >= lo_s) |=> (cr[g] <= $past(cr[g])));
    end

endmodule

bind cbs_shaper cbs_shaper_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/tb_cbs_shaper.sv
`timescale 1ns/1ps
module tb_cbs_shaper;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int CW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    q_nonempty;
    logic            tx_busy;
    logic [CW-1:0]   tx_cls;
    logic [N*W-1:0]  idle_inc, send_inc;
    logic [W-1:0]    cred_max, cred_min;
    logic [N-1:0]    eligible;
    logic            pick_valid;
    logic [CW-1:0]   pick_cls;
    logic [N*W-1:0]  credit;

    int checks   = 0;
    int failures = 0;
    int m_cr [N];
    int idle [N];
    int sndv [N];
    int hi_l, lo_l;

    always #5 clk = ~clk;

    cbs_shaper #(.N(N), .W(W)) dut (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic load_cfg();
        for (int i = 0; i < N; i++) begin
            idle_inc[i*W +: W] = W'(idle[i]);
            send_inc[i*W +: W] = W'(sndv[i]);
        end
        cred_max = W'(hi_l);
        cred_min = W'(lo_l);
    endtask

    task automatic compare_now();
        int best;
        for (int i = 0; i < N; i++) begin
            // R7: eligible = queue flag and non-negative credit
            chk("R7", $sformatf("eligible[%0d]", i), int'(eligible[i]),
                int'(q_nonempty[i] && m_cr[i] >= 0));
        end
        best = -1;
        for (int i = 0; i < N; i++)
            if (q_nonempty[i] && m_cr[i] >= 0) best = i;
        if (tx_busy) begin
            chk("R9", "pick_valid in flight", int'(pick_valid), 0);
        end else begin
            chk("R8", "pick_valid", int'(pick_valid), int'(best >= 0));
            if (best >= 0) chk("R8", "pick_cls", int'(pick_cls), best);
        end
    endtask

    // Inputs are already driven; advance one clock and compare against the model.
    task automatic step();
        int    nx [N];
        string tg [N];
        int    raw;
        for (int i = 0; i < N; i++) begin
            if (tx_busy && int'(tx_cls) == i) begin
                raw = m_cr[i] + sndv[i]; tg[i] = "R3";
            end else if (q_nonempty[i]) begin
                raw = m_cr[i] + idle[i]; tg[i] = "R2";
            end else if (m_cr[i] < 0) begin
                raw = m_cr[i] + idle[i]; if (raw > 0) raw = 0; tg[i] = "R5";
            end else begin
                raw = 0; tg[i] = "R4";
            end
            if (raw > hi_l)      begin nx[i] = hi_l; tg[i] = "R6"; end
            else if (raw < lo_l) begin nx[i] = lo_l; tg[i] = "R6"; end
            else                 nx[i] = raw;
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            m_cr[i] = nx[i];
            chk(tg[i], $sformatf("credit[%0d]", i),
                int'($signed(credit[i*W +: W])), m_cr[i]);
        end
        compare_now();
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int frame_left;
        rst_n      = 1'b0;
        q_nonempty = '0;
        tx_busy    = 1'b0;
        tx_cls     = '0;
        idle = '{10, 20, 30, 40};
        for (int i = 0; i < N; i++) sndv[i] = idle[i] - 100;
        hi_l = 1000; lo_l = -1000;
        load_cfg();
        for (int i = 0; i < N; i++) m_cr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < N; i++)
            chk("R1", $sformatf("reset credit[%0d]", i), int'($signed(credit[i*W +: W])), 0);
        chk("R1", "reset eligible", int'(eligible), 0);
        chk("R1", "reset pick_valid", int'(pick_valid), 0);

        // Idle, all empty: credits stay zero (R4)
        run(3);

        // R2 / R8: classes 1 and 3 waiting accrue; class 3 is picked
        q_nonempty = 4'b1010;
        run(5);

        // R3 / R9 / R6: class 3 sends a long frame, through zero down to the lower limit
        tx_busy = 1'b1; tx_cls = 2'd3;
        run(22);

        // R5: class 3 empties with negative credit and recovers without overshoot;
        // R6: class 1 saturates at the upper limit
        tx_busy = 1'b0; q_nonempty = 4'b0010;
        run(60);

        // R4: class 1 empties with positive credit and clears
        q_nonempty = 4'b0000;
        run(3);

        // R8: all waiting, the highest index wins; then class 3 goes negative
        q_nonempty = 4'b1111;
        run(2);
        tx_busy = 1'b1; tx_cls = 2'd3;
        run(2);
        tx_busy = 1'b0;
        run(1);

        // Mixed traffic with new limits and slopes
        hi_l = 300; lo_l = -400;
        for (int i = 0; i < N; i++) begin
            idle[i] = 5 + 15 * i;
            sndv[i] = idle[i] - 120;
        end
        load_cfg();
        frame_left = 0;
        for (int k = 0; k < 400; k++) begin
            if (k % 7 == 0) q_nonempty = N'($urandom);
            if (frame_left > 0) begin
                frame_left--;
                if (frame_left == 0) tx_busy = 1'b0;
            end else if (pick_valid && ($urandom % 2 == 0)) begin
                tx_busy    = 1'b1;
                tx_cls     = pick_cls;
                frame_left = 1 + int'($urandom % 8);
            end
            if (k == 200) begin
                for (int i = 0; i < N; i++) begin
                    idle[i] = int'($urandom % 60);
                    sndv[i] = idle[i] - 90;
                end
                load_cfg();
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule